// File: doc/BRIEF.md
# Split Control/Status Register Bank with AXI4-Lite Access

This block is an AXI4-Lite slave that gives software a small bank of 32-bit word registers. Registers sit at consecutive word addresses, four bytes apart, starting at offset zero. The lower half of the bank holds control words that software both writes and reads back. The upper half holds status words. Software can read these but cannot change them. Fabric logic loads them through a dedicated load port instead.

The register index comes from the address bits just above the two-bit byte offset. The index field is exactly wide enough to count the implemented registers, so it can name more slots than exist. Those unused slots behave cleanly: a read returns zero and a write is accepted and discarded. Write address and write data may arrive in either order. Each read and each write completes with one OKAY response that stays valid until the master takes it.

Top module: `regbank_axil`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high and in the cycle after it, AWREADY, WREADY, ARREADY, BVALID and RVALID are low. Every register then reads zero.
- R2: A write to a control index (0 to NUM_REGS/2-1) updates only the byte lanes whose WSTRB bit is set. Bit k of WSTRB covers data bits 8k+7:8k. A later read returns the merged word.
- R3: A software write to a status index (NUM_REGS/2 to NUM_REGS-1) gets an OKAY response and changes no register.
- R4: When bit i of `sts_load` is high on a clock edge, status index NUM_REGS/2+i takes the full word `sts_word[32i+31:32i]`. Byte strobes play no part in this.
- R5: An index at or above NUM_REGS but inside the index field (6 and 7 with the default) reads zero. A write there gets OKAY and changes no register, so that index still reads zero afterwards.
- R6: The index is `addr[IDX_W+1:2]`, where IDX_W = clog2(NUM_REGS). The byte-offset bits [1:0] are ignored, and so are the address bits above the index field.
- R7: AW and W are each accepted on their own handshake, in either order. The register update happens only once both are held. Exactly one BVALID follows and stays high until BREADY. AWREADY and WREADY stay low while a beat of their own is held or BVALID is pending.
- R8: A read is accepted when ARREADY and ARVALID are high and RVALID is low. RVALID then stays high, with RDATA stable, until RREADY. ARREADY is low while RVALID is high.
- R9: BRESP and RRESP are always 2'b00 (OKAY).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| awvalid | input | 1 | Write address valid |
| awaddr | input | ADDR_W | Write byte address |
| awready | output | 1 | Write address ready |
| wvalid | input | 1 | Write data valid |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte lane enables |
| wready | output | 1 | Write data ready |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| araddr | input | ADDR_W | Read byte address |
| arready | output | 1 | Read address ready |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code |
| sts_load | input | NUM_REGS-NUM_REGS/2 | Per-status-word load enable from fabric |
| sts_word | input | 32*(NUM_REGS-NUM_REGS/2) | Packed status load values from fabric |

## Verification
The bench uses the defaults NUM_REGS=6 and ADDR_W=8. This gives three control words and three status words, and a 3-bit index field that leaves slots 6 and 7 unused. Address bits 7:5 lie above the index field, so the same random stimulus reaches control, status and unused slots, and also aliased and misaligned addresses. Random response back-pressure and all three AW/W arrival orders exercise the handshake holding rules.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int WORD_W    = 32;
    localparam int LANES     = WORD_W / 8;
    localparam int ADDR_LSB  = $clog2(LANES);
    localparam int IDX_MAX_W = 8;

    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [LANES-1:0]     lanes_t;
    typedef logic [IDX_MAX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_SLVERR = 2'b10
    } resp_e;

    typedef struct packed {
        logic   en;
        idx_t   idx;
        word_t  data;
        lanes_t lanes;
    } wr_req_t;

    function automatic word_t merge_lanes(word_t old_w, word_t new_w, lanes_t sel);
        word_t res;
        for (int b = 0; b < LANES; b++) begin
            res[b*8 +: 8] = sel[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/regbank_wr_chan.sv
module regbank_wr_chan
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              live,
    input  logic              awvalid,
    input  logic [ADDR_W-1:0] awaddr,
    output logic              awready,
    input  logic              wvalid,
    input  word_t             wdata,
    input  lanes_t            wstrb,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    output logic [1:0]        bresp,
    output wr_req_t           req
);

    logic              aw_held;
    logic              w_held;
    logic              resp_pend;
    logic [ADDR_W-1:0] aw_q;
    word_t             w_data_q;
    lanes_t            w_lanes_q;

    assign awready = live & ~aw_held & ~resp_pend;
    assign wready  = live & ~w_held & ~resp_pend;
    assign bvalid  = resp_pend;
    assign bresp   = RESP_OKAY;

    always_comb begin
        req.en    = aw_held & w_held;
        req.idx   = idx_t'(aw_q[ADDR_LSB +: IDX_W]);
        req.data  = w_data_q;
        req.lanes = w_lanes_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_held   <= 1'b0;
            w_held    <= 1'b0;
            resp_pend <= 1'b0;
            aw_q      <= '0;
            w_data_q  <= '0;
            w_lanes_q <= '0;
        end else begin
            if (awvalid && awready) begin
                aw_held <= 1'b1;
                aw_q    <= awaddr;
            end
            if (wvalid && wready) begin
                w_held    <= 1'b1;
                w_data_q  <= wdata;
                w_lanes_q <= wstrb;
            end
            if (aw_held && w_held) begin
                aw_held   <= 1'b0;
                w_held    <= 1'b0;
                resp_pend <= 1'b1;
            end else if (resp_pend && bready) begin
                resp_pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/regbank_rd_chan.sv
module regbank_rd_chan
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              live,
    input  logic              arvalid,
    input  logic [ADDR_W-1:0] araddr,
    output logic              arready,
    output logic              rvalid,
    input  logic              rready,
    output word_t             rdata,
    output logic [1:0]        rresp,
    output idx_t              rd_idx,
    input  word_t             rd_word
);

    logic  data_pend;
    word_t data_q;
    logic  take;

    assign arready = live & ~data_pend;
    assign take    = arready & arvalid & ~data_pend;
    assign rd_idx  = idx_t'(araddr[ADDR_LSB +: IDX_W]);
    assign rvalid  = data_pend;
    assign rdata   = data_q;
    assign rresp   = RESP_OKAY;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_pend <= 1'b0;
            data_q    <= '0;
        end else if (take) begin
            data_pend <= 1'b1;
            data_q    <= rd_word;
        end else if (data_pend && rready) begin
            data_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/regbank_store.sv
module regbank_store
    import regbank_pkg::*;
#(
    parameter int NCTL = 3,
    parameter int NSTS = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wr_req_t               req,
    input  logic [NSTS-1:0]       sts_load,
    input  logic [NSTS*WORD_W-1:0] sts_word,
    input  idx_t                  rd_idx,
    output word_t                 rd_word
);

    word_t ctl_q [NCTL];
    word_t sts_q [NSTS];

    for (genvar i = 0; i < NCTL; i++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q[i] <= '0;
            end else if (req.en && req.idx == idx_t'(i)) begin
                ctl_q[i] <= merge_lanes(ctl_q[i], req.data, req.lanes);
            end
        end
    end

    for (genvar j = 0; j < NSTS; j++) begin : g_sts
        always_ff @(posedge clk) begin
            if (rst) begin
                sts_q[j] <= '0;
            end else if (sts_load[j]) begin
                sts_q[j] <= sts_word[j*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NCTL; k++) begin
            if (rd_idx == idx_t'(k)) rd_word = ctl_q[k];
        end
        for (int k = 0; k < NSTS; k++) begin
            if (rd_idx == idx_t'(NCTL + k)) rd_word = sts_q[k];
        end
    end

endmodule

// File: rtl/regbank_axil.sv
module regbank_axil
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = 6,
    parameter int ADDR_W   = 8,
    localparam int NCTL    = NUM_REGS / 2,
    localparam int NSTS    = NUM_REGS - NCTL,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   awvalid,
    input  logic [ADDR_W-1:0]      awaddr,
    output logic                   awready,
    input  logic                   wvalid,
    input  logic [31:0]            wdata,
    input  logic [3:0]             wstrb,
    output logic                   wready,
    output logic                   bvalid,
    input  logic                   bready,
    output logic [1:0]             bresp,
    input  logic                   arvalid,
    input  logic [ADDR_W-1:0]      araddr,
    output logic                   arready,
    output logic                   rvalid,
    input  logic                   rready,
    output logic [31:0]            rdata,
    output logic [1:0]             rresp,
    input  logic [NSTS-1:0]        sts_load,
    input  logic [NSTS*32-1:0]     sts_word
);

    logic    live;
    wr_req_t wreq;
    idx_t    rd_idx;
    word_t   rd_word;

    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    regbank_wr_chan #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_wr (
        .clk(clk), .rst(rst), .live(live),
        .awvalid(awvalid), .awaddr(awaddr), .awready(awready),
        .wvalid(wvalid), .wdata(wdata), .wstrb(wstrb), .wready(wready),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .req(wreq)
    );

    regbank_rd_chan #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rd (
        .clk(clk), .rst(rst), .live(live),
        .arvalid(arvalid), .araddr(araddr), .arready(arready),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
        .rd_idx(rd_idx), .rd_word(rd_word)
    );

    regbank_store #(.NCTL(NCTL), .NSTS(NSTS)) u_store (
        .clk(clk), .rst(rst), .req(wreq),
        .sts_load(sts_load), .sts_word(sts_word),
        .rd_idx(rd_idx), .rd_word(rd_word)
    );

endmodule

// File: rtl/regbank_axil_chk.sv
module regbank_axil_chk (
    input logic        clk,
    input logic        rst,
    input logic        awready,
    input logic        wready,
    input logic        bvalid,
    input logic        bready,
    input logic        arready,
    input logic        rvalid,
    input logic        rready,
    input logic [31:0] rdata
);

    logic rst_d;

    always_ff @(posedge clk) rst_d <= rst;

    // R1: all handshake outputs idle in the cycle following a reset edge
    always @(negedge clk) begin
        if (rst_d === 1'b1) begin
            a_r1_idle_after_reset: assert (!awready && !wready && !arready && !bvalid && !rvalid);
        end
    end

    a_r7_bvalid_hold: assert property (@(posedge clk) disable iff (rst)
        bvalid && !bready |=> bvalid);

    a_r7_no_accept_while_resp: assert property (@(posedge clk) disable iff (rst)
        bvalid |-> !awready && !wready);

    a_r8_rdata_stable: assert property (@(posedge clk) disable iff (rst)
        rvalid && !rready |=> rvalid && $stable(rdata));

    a_r8_no_ar_while_rvalid: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> !arready);

endmodule

bind regbank_axil regbank_axil_chk u_chk (.*);

// File: tb/sim_regbank_axil.sv
module sim_regbank_axil;

    localparam int NUM_REGS = 6;
    localparam int NCTL     = NUM_REGS / 2;
    localparam int NSTS     = NUM_REGS - NCTL;
    localparam int ADDR_W   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic [NSTS-1:0]    sts_load = '0;
    logic [NSTS*32-1:0] sts_word = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] model [8];

    always #2.5 clk = ~clk;

    regbank_axil #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst),
        .awvalid(awvalid), .awaddr(awaddr), .awready(awready),
        .wvalid(wvalid), .wdata(wdata), .wstrb(wstrb), .wready(wready),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .arvalid(arvalid), .araddr(araddr), .arready(arready),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
        .sts_load(sts_load), .sts_word(sts_word)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int idx_of(logic [ADDR_W-1:0] a);
        return int'((a >> 2) & 8'd7);
    endfunction

    function automatic logic [31:0] merged(logic [31:0] o, logic [31:0] n, logic [3:0] s);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = n[b*8 +: 8];
        return r;
    endfunction

    // mode 0: AW and W together, 1: AW first, 2: W first
    task automatic axi_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                             input logic [3:0] s, input int mode, input int hold);
        bit aw_todo = 1, w_todo = 1, aw_hs, w_hs;
        int i;
        while (aw_todo || w_todo) begin
            @(negedge clk);
            if (!(aw_todo && w_todo))
                chk(bvalid == 1'b0, "R7", "bvalid before both beats", 32'(bvalid), 0);
            awvalid = aw_todo && (mode != 2 || !w_todo);
            wvalid  = w_todo && (mode != 1 || !aw_todo);
            awaddr = a; wdata = d; wstrb = s;
            aw_hs = awvalid && awready;
            w_hs  = wvalid && wready;
            @(posedge clk);
            if (aw_hs) aw_todo = 0;
            if (w_hs)  w_todo  = 0;
        end
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        i = 0;
        while (!bvalid && i < 20) begin @(negedge clk); i++; end
        chk(bvalid == 1'b1, "R7", "bvalid after both beats", 32'(bvalid), 1);
        chk(bresp == 2'b00, "R9", "bresp", 32'(bresp), 0);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(bvalid == 1'b1, "R7", "bvalid held", 32'(bvalid), 1);
        end
        bready = 1;
        @(negedge clk);
        bready = 0;
        chk(bvalid == 1'b0, "R7", "single response", 32'(bvalid), 0);
        if (idx_of(a) < NCTL) model[idx_of(a)] = merged(model[idx_of(a)], d, s);
    endtask

    task automatic axi_read(input logic [ADDR_W-1:0] a, input int hold, output logic [31:0] d);
        bit hs = 0;
        logic [31:0] first;
        while (!hs) begin
            @(negedge clk);
            arvalid = 1; araddr = a;
            hs = arready;
            @(posedge clk);
        end
        @(negedge clk);
        arvalid = 0;
        chk(rvalid == 1'b1, "R8", "rvalid after accept", 32'(rvalid), 1);
        chk(arready == 1'b0, "R8", "arready while rvalid", 32'(arready), 0);
        chk(rresp == 2'b00, "R9", "rresp", 32'(rresp), 0);
        first = rdata;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(rvalid && rdata == first, "R8", "rdata held", rdata, first);
        end
        d = rdata;
        rready = 1;
        @(negedge clk);
        rready = 0;
        chk(rvalid == 1'b0, "R8", "rvalid cleared", 32'(rvalid), 0);
    endtask

    task automatic load_sts(input logic [NSTS-1:0] m, input logic [NSTS*32-1:0] v);
        @(negedge clk);
        sts_load = m; sts_word = v;
        @(negedge clk);
        sts_load = '0;
        for (int j = 0; j < NSTS; j++) if (m[j]) model[NCTL + j] = v[j*32 +: 32];
    endtask

    task automatic read_expect(input logic [ADDR_W-1:0] a, input string req);
        logic [31:0] got;
        axi_read(a, int'($urandom % 3), got);
        chk(got == model[idx_of(a)], req, $sformatf("read addr %h", a), got, model[idx_of(a)]);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] got;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 8; k++) model[k] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!awready && !wready && !arready && !bvalid && !rvalid, "R1", "outputs in reset",
            {27'd0, awready, wready, arready, bvalid, rvalid}, 0);
        rst = 0;
        @(negedge clk);
        @(negedge clk);
        chk(awready && wready && arready, "R1", "ready after reset",
            {29'd0, awready, wready, arready}, 32'h7);
        for (int k = 0; k < 8; k++) read_expect(ADDR_W'(k * 4), "R1");

        // R2: full and partial strobes on control words
        axi_write(8'h00, 32'hA5A5_1234, 4'hF, 0, 0);
        read_expect(8'h00, "R2");
        axi_write(8'h04, 32'hFFFF_FFFF, 4'hF, 1, 2);
        axi_write(8'h04, 32'h1122_3344, 4'b0101, 2, 1);
        read_expect(8'h04, "R2");
        chk(model[1] == 32'hFF22_FF44, "R2", "strobe model", model[1], 32'hFF22_FF44);

        // R4: fabric load into status words
        load_sts(3'b101, {32'hCAFE_0002, 32'h0BAD_0001, 32'hBEEF_0000});
        read_expect(8'h0C, "R4");
        read_expect(8'h14, "R4");
        read_expect(8'h10, "R4");

        // R3: software write to status word is dropped
        axi_write(8'h0C, 32'h0000_0000, 4'hF, 0, 0);
        read_expect(8'h0C, "R3");
        chk(model[3] == 32'hBEEF_0000, "R3", "status kept", model[3], 32'hBEEF_0000);

        // R5: unused indices 6 and 7
        axi_write(8'h18, 32'h0000_0018, 4'hF, 0, 0);
        axi_write(8'h1C, 32'hDEAD_BEEF, 4'hF, 2, 0);
        read_expect(8'h18, "R5");
        read_expect(8'h1C, "R5");
        for (int k = 0; k < NUM_REGS; k++) read_expect(ADDR_W'(k * 4), "R5");

        // R6: upper bits and byte offset ignored
        axi_write(8'hE9, 32'h6666_0006, 4'hF, 0, 0);
        axi_read(8'h08, 0, got);
        chk(got == 32'h6666_0006, "R6", "alias write lands on index 2", got, 32'h6666_0006);
        axi_read(8'h2B, 1, got);
        chk(got == 32'h6666_0006, "R6", "alias read of index 2", got, 32'h6666_0006);

        // random mix of R2..R8
        for (int n = 0; n < 400; n++) begin
            int op = int'($urandom % 4);
            logic [ADDR_W-1:0] a = ADDR_W'($urandom);
            if (op == 0) begin
                axi_write(a, $urandom, 4'($urandom), int'($urandom % 3), int'($urandom % 3));
            end else if (op == 1) begin
                load_sts(NSTS'($urandom), {$urandom, $urandom, $urandom});
            end else begin
                read_expect(a, "R2");
            end
        end

        // R1: reset clears everything again
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        for (int k = 0; k < 8; k++) model[k] = '0;
        @(negedge clk);
        for (int k = 0; k < 8; k++) read_expect(ADDR_W'(k * 4), "R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule